// File: doc/BRIEF.md
# Shared Bus Occupancy and Retry Controller

This block sits at the centre of a shared memory bus with N attached ports. A port offers one timing packet at a time: its source index, a destination (a port index or the broadcast code), whether it is a request or a response, whether it carries a payload, the payload size in bytes and the target address. In the same cycle the block decides whether the packet is accepted, and routes it to a destination. It also works out how many cycles the accepted packet keeps the bus to itself.

Senders that are turned away are remembered in a first-in first-out retry list, each port at most once. While that list holds entries, only the port at its head may get onto the bus. Once the bus is idle, the head receives a one-cycle retry strobe, and it leaves the list only when its resend is accepted. A broadcast packet first snoops every other port. A snoop may refuse the packet. It may satisfy it as a cache-to-cache transfer, so that nothing is forwarded. Otherwise the destination is taken from an address decode.

Top module: `shbus_arbiter`

## Requirements
- R1: An accepted request packet keeps `bus_busy` high for exactly 1 cycle, the cycle after the one in which it was accepted, whatever its data flag.
- R2: An accepted response with `snd_has_data`=1 and size S (1..MAX_BYTES) keeps `bus_busy` high for ceil(S / BUS_BYTES) cycles, starting in the cycle after acceptance.
- R3: An accepted response without data keeps `bus_busy` high for exactly 1 cycle after acceptance.
- R4: While `bus_busy` is high, a valid packet is refused, and its source is appended to the retry list if it is not already in it.
- R5: While the retry list is not empty, a packet from any source other than the head is refused and appended, without duplication. The list keeps arrival order.
- R6: `retry_strobe` is one-hot at the head's index when the bus is idle and the list is not empty, and zero otherwise. The head is removed only in the cycle its resend is accepted.
- R7: A unicast packet (destination code 0..N-1) whose destination has `dst_ready` low is refused and its source appended. When the destination is ready, the packet is accepted with `fwd_valid`=1 and `fwd_port`=destination.
- R8: A broadcast packet (destination code all ones) that passes the busy/queue gate drives `snoop_req` high on every port except the source. If any of those ports has `snoop_ok` low, the packet is refused and its source appended.
- R9: If all snoops agree and any snooped port raises `snoop_sat`, the packet is accepted with `fwd_sat`=1 and `fwd_valid`=0.
- R10: Otherwise a broadcast goes to the port picked by the address region: port k owns addresses from k*REGION upward, with REGION = 2^ADDR_W / N. The packet is forwarded if that port is ready and refused and appended if it is not.
- R11: A unicast destination equal to the source or not below N, or a decoded broadcast target equal to the source, raises `dest_err`. Such a packet is refused and is not added to the retry list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | 1 | A packet is offered this cycle |
| snd_src | input | PW | Sending port index |
| snd_dst | input | PW+1 | Destination port, all ones = broadcast |
| snd_is_req | input | 1 | 1 = request, 0 = response |
| snd_has_data | input | 1 | Packet carries a payload |
| snd_size | input | SW | Payload bytes |
| snd_addr | input | ADDR_W | Target address |
| snd_accept | output | 1 | Packet accepted this cycle |
| dst_ready | input | N | Per-port ability to take a forwarded packet |
| fwd_valid | output | 1 | Packet forwarded to fwd_port |
| fwd_port | output | PW | Forwarding destination |
| fwd_sat | output | 1 | Broadcast satisfied by a snooped port |
| snoop_req | output | N | Snoop issued to each port |
| snoop_ok | input | N | Snooped port accepts the snoop |
| snoop_sat | input | N | Snooped port satisfies the packet |
| bus_busy | output | 1 | Bus held by an earlier packet |
| retry_strobe | output | N | Retry grant to the head of the list |
| dest_err | output | 1 | Illegal destination seen |

## Verification
The accept, routing, snoop and error outputs are due in the same cycle as the offered packet. The bench drives inputs at the falling edge and samples these outputs one nanosecond later, before the rising edge. `bus_busy` rises in the first cycle after acceptance and stays high for the hold count, and the retry strobe reflects the list as it stands after the edge that closed the refusing cycle. The bench's model therefore advances its busy count and its queue only after each sample, so every expected value belongs to the cycle being observed.

// File: rtl/shbus_pkg.sv
`timescale 1ns/1ps
package shbus_pkg;
   typedef enum logic [1:0] {
      RT_IDLE  = 2'd0,
      RT_QUEUE = 2'd1,
      RT_ERR   = 2'd2,
      RT_TAKE  = 2'd3
   } route_e;

   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction
endpackage

// File: rtl/shbus_hold_calc.sv
`timescale 1ns/1ps
module shbus_hold_calc #(
   parameter int BUS_BYTES = 8,
   parameter int SW        = 7,
   parameter int MAX_HOLD  = 8,
   parameter int CW        = 4
) (
   input  logic          is_req,
   input  logic          has_data,
   input  logic [SW-1:0] size,
   output logic [CW-1:0] hold
);
   localparam bit POW2 = (BUS_BYTES & (BUS_BYTES - 1)) == 0;
   logic [CW-1:0] data_beats;

   generate
      if (POW2) begin : g_shift
         localparam int LB = $clog2(BUS_BYTES);
         logic [SW:0] padded;
         assign padded     = (SW+1)'(size) + (SW+1)'(BUS_BYTES - 1);
         assign data_beats = CW'(padded >> LB);
      end else begin : g_step
         always_comb begin
            data_beats = '0;
            for (int k = 0; k < MAX_HOLD; k++) begin
               if (k * BUS_BYTES < int'(size))
                  data_beats = data_beats + CW'(1);
            end
         end
      end
   endgenerate

   always_comb begin
      if (is_req)        hold = CW'(1);
      else if (has_data) hold = data_beats;
      else               hold = CW'(1);
   end
endmodule

// File: rtl/shbus_retry_list.sv
`timescale 1ns/1ps
module shbus_retry_list #(
   parameter int N  = 4,
   parameter int PW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [PW-1:0] push_id,
   input  logic          pop,
   output logic          empty,
   output logic [PW-1:0] head
);
   logic [PW-1:0] slot [N];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [PW:0]   count;
   logic [N-1:0]  member;
   logic          do_push, do_pop;

   function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
      return (p == PW'(N - 1)) ? '0 : p + PW'(1);
   endfunction

   assign empty   = (count == '0);
   assign head    = slot[rd_ptr];
   assign do_pop  = pop && !empty;
   assign do_push = push && !member[push_id] && (int'(count) < N);

   always_ff @(posedge clk) begin
      if (do_push) slot[wr_ptr] <= push_id;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
         member <= '0;
      end else begin
         if (do_pop) begin
            rd_ptr               <= step_ptr(rd_ptr);
            member[slot[rd_ptr]] <= 1'b0;
         end
         if (do_push) begin
            wr_ptr          <= step_ptr(wr_ptr);
            member[push_id] <= 1'b1;
         end
         case ({do_push, do_pop})
            2'b10:   count <= count + (PW+1)'(1);
            2'b01:   count <= count - (PW+1)'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/shbus_route.sv
`timescale 1ns/1ps
module shbus_route
   import shbus_pkg::*;
#(
   parameter int N      = 4,
   parameter int PW     = 2,
   parameter int DW     = 3,
   parameter int ADDR_W = 16
) (
   input  logic              valid,
   input  logic              gate,
   input  logic [PW-1:0]     src,
   input  logic [DW-1:0]     dst,
   input  logic [ADDR_W-1:0] addr,
   input  logic [N-1:0]      dst_ready,
   input  logic [N-1:0]      snoop_ok,
   input  logic [N-1:0]      snoop_sat,
   output logic              accept,
   output logic              enqueue,
   output logic              err,
   output logic              fwd_valid,
   output logic [PW-1:0]     fwd_port,
   output logic              sat,
   output logic [N-1:0]      snoop_req
);
   localparam longint REGION = (longint'(1) << ADDR_W) / N;

   route_e        outcome;
   logic          is_bcast;
   logic [N-1:0]  others;
   logic [PW-1:0] region_tgt;
   logic [PW-1:0] uni_tgt;

   assign is_bcast = (dst == {DW{1'b1}});
   assign others   = ~(N'(1) << src);
   assign uni_tgt  = dst[PW-1:0];

   always_comb begin
      region_tgt = '0;
      for (int k = 1; k < N; k++) begin
         if (longint'(addr) >= longint'(k) * REGION)
            region_tgt = PW'(k);
      end
   end

   always_comb begin
      outcome   = RT_IDLE;
      sat       = 1'b0;
      fwd_port  = '0;
      snoop_req = '0;
      if (valid) begin
         if (gate) begin
            outcome = RT_QUEUE;
         end else if (!is_bcast) begin
            if (int'(dst) >= N || uni_tgt == src) outcome = RT_ERR;
            else if (dst_ready[uni_tgt]) begin
               outcome  = RT_TAKE;
               fwd_port = uni_tgt;
            end else outcome = RT_QUEUE;
         end else begin
            snoop_req = others;
            if (|(others & ~snoop_ok)) outcome = RT_QUEUE;
            else if (|(others & snoop_sat)) begin
               outcome = RT_TAKE;
               sat     = 1'b1;
            end else if (region_tgt == src) outcome = RT_ERR;
            else if (dst_ready[region_tgt]) begin
               outcome  = RT_TAKE;
               fwd_port = region_tgt;
            end else outcome = RT_QUEUE;
         end
      end
   end

   assign accept    = (outcome == RT_TAKE);
   assign enqueue   = (outcome == RT_QUEUE);
   assign err       = (outcome == RT_ERR);
   assign fwd_valid = accept && !sat;
endmodule

// File: rtl/shbus_arbiter.sv
`timescale 1ns/1ps
module shbus_arbiter #(
   parameter int N         = 4,
   parameter int BUS_BYTES = 8,
   parameter int MAX_BYTES = 64,
   parameter int ADDR_W    = 16,
   localparam int PW       = $clog2(N),
   localparam int DW       = PW + 1,
   localparam int SW       = $clog2(MAX_BYTES + 1),
   localparam int MAX_HOLD = (MAX_BYTES + BUS_BYTES - 1) / BUS_BYTES,
   localparam int CW       = $clog2(MAX_HOLD + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snd_valid,
   input  logic [PW-1:0]     snd_src,
   input  logic [DW-1:0]     snd_dst,
   input  logic              snd_is_req,
   input  logic              snd_has_data,
   input  logic [SW-1:0]     snd_size,
   input  logic [ADDR_W-1:0] snd_addr,
   output logic              snd_accept,
   input  logic [N-1:0]      dst_ready,
   output logic              fwd_valid,
   output logic [PW-1:0]     fwd_port,
   output logic              fwd_sat,
   output logic [N-1:0]      snoop_req,
   input  logic [N-1:0]      snoop_ok,
   input  logic [N-1:0]      snoop_sat,
   output logic              bus_busy,
   output logic [N-1:0]      retry_strobe,
   output logic              dest_err
);
   initial begin : elab_checks
      assert (N >= 2) else $fatal(1, "shbus_arbiter: N must be at least 2");
      assert (BUS_BYTES >= 1) else $fatal(1, "shbus_arbiter: BUS_BYTES must be positive");
      assert (MAX_BYTES >= BUS_BYTES) else $fatal(1, "shbus_arbiter: MAX_BYTES below BUS_BYTES");
      assert (ADDR_W >= PW && ADDR_W <= 30) else $fatal(1, "shbus_arbiter: ADDR_W out of range");
   end

   logic [CW-1:0] busy_cnt;
   logic [CW-1:0] hold;
   logic          list_empty;
   logic [PW-1:0] list_head;
   logic          gate;
   logic          enqueue;

   shbus_hold_calc #(
      .BUS_BYTES(BUS_BYTES), .SW(SW), .MAX_HOLD(MAX_HOLD), .CW(CW)
   ) hold_i (
      .is_req(snd_is_req), .has_data(snd_has_data), .size(snd_size), .hold(hold)
   );

   assign bus_busy = (busy_cnt != '0);
   assign gate     = bus_busy || (!list_empty && (snd_src != list_head));

   shbus_route #(
      .N(N), .PW(PW), .DW(DW), .ADDR_W(ADDR_W)
   ) route_i (
      .valid(snd_valid), .gate(gate), .src(snd_src), .dst(snd_dst),
      .addr(snd_addr), .dst_ready(dst_ready), .snoop_ok(snoop_ok),
      .snoop_sat(snoop_sat), .accept(snd_accept), .enqueue(enqueue),
      .err(dest_err), .fwd_valid(fwd_valid), .fwd_port(fwd_port),
      .sat(fwd_sat), .snoop_req(snoop_req)
   );

   shbus_retry_list #(.N(N), .PW(PW)) list_i (
      .clk(clk), .rst_n(rst_n), .push(enqueue), .push_id(snd_src),
      .pop(snd_accept), .empty(list_empty), .head(list_head)
   );

   assign retry_strobe = (!bus_busy && !list_empty) ? (N'(1) << list_head) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)                busy_cnt <= '0;
      else if (snd_accept)       busy_cnt <= hold;
      else if (busy_cnt != '0)   busy_cnt <= busy_cnt - CW'(1);
   end
endmodule

// File: rtl/shbus_arbiter_chk.sv
`timescale 1ns/1ps
module shbus_arbiter_chk #(
   parameter int N = 4, parameter int BUS_BYTES = 8, parameter int PW = 2,
   parameter int DW = 3, parameter int SW = 7
) (
   input logic clk, input logic rst_n, input logic snd_valid,
   input logic [PW-1:0] snd_src, input logic [DW-1:0] snd_dst,
   input logic snd_is_req, input logic snd_has_data, input logic [SW-1:0] snd_size,
   input logic snd_accept, input logic [N-1:0] dst_ready, input logic fwd_valid,
   input logic [PW-1:0] fwd_port, input logic fwd_sat, input logic [N-1:0] snoop_req,
   input logic bus_busy, input logic [N-1:0] retry_strobe, input logic dest_err
);
   p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_accept && snd_is_req) |=> bus_busy ##1 !bus_busy);

   p_short_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_accept && !snd_is_req && snd_has_data && snd_size != '0 &&
       int'(snd_size) <= BUS_BYTES) |=> bus_busy ##1 !bus_busy);

   p_nodata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_accept && !snd_is_req && !snd_has_data) |=> bus_busy ##1 !bus_busy);

   p_busy_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_busy |-> !snd_accept);

   p_no_overtake_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && (|retry_strobe) && !retry_strobe[snd_src]) |-> !snd_accept);

   p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(retry_strobe));

   p_strobe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|retry_strobe) |-> !bus_busy);

   p_fwd_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> (snd_accept && dst_ready[fwd_port] && fwd_port != snd_src));

   p_snoop_skip_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      snd_valid |-> !snoop_req[snd_src]);

   p_sat_no_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_sat |-> (snd_accept && !fwd_valid && snd_dst == {DW{1'b1}}));

   p_err_refused_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dest_err |-> !snd_accept);
endmodule

bind shbus_arbiter shbus_arbiter_chk #(
   .N(N), .BUS_BYTES(BUS_BYTES), .PW(PW), .DW(DW), .SW(SW)
) chk_i (
   .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_src(snd_src),
   .snd_dst(snd_dst), .snd_is_req(snd_is_req), .snd_has_data(snd_has_data),
   .snd_size(snd_size), .snd_accept(snd_accept), .dst_ready(dst_ready),
   .fwd_valid(fwd_valid), .fwd_port(fwd_port), .fwd_sat(fwd_sat),
   .snoop_req(snoop_req), .bus_busy(bus_busy), .retry_strobe(retry_strobe),
   .dest_err(dest_err)
);

// File: tb/shbus_arbiter_tb.sv
`timescale 1ns/1ps
module shbus_arbiter_tb_top;
   localparam int N = 4, BB = 8, MB = 64, AW = 16;
   localparam int PW = 2, DW = 3, SW = 7;
   localparam int BCAST = 7;
   localparam int REGION = 16384;

   logic clk = 1'b0, rst_n = 1'b0;
   logic snd_valid = 0, snd_is_req = 0, snd_has_data = 0;
   logic [PW-1:0] snd_src = '0;
   logic [DW-1:0] snd_dst = '0;
   logic [SW-1:0] snd_size = '0;
   logic [AW-1:0] snd_addr = '0;
   logic [N-1:0]  dst_ready = '0, snoop_ok = '0, snoop_sat = '0;
   logic snd_accept, fwd_valid, fwd_sat, bus_busy, dest_err;
   logic [PW-1:0] fwd_port;
   logic [N-1:0]  snoop_req, retry_strobe;

   int n_checks = 0, n_fail = 0;
   bit done = 0;
   int q[$];
   int mbusy = 0;
   string hold_tag = "R1";

   always #2 clk = ~clk;

   shbus_arbiter #(.N(N), .BUS_BYTES(BB), .MAX_BYTES(MB), .ADDR_W(AW)) dut_i (.*);

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int exp_hold(input bit rq, input bit hd, input int sz);
      if (rq) return 1;
      if (hd) return (sz + BB - 1) / BB;
      return 1;
   endfunction

   function automatic bit in_q(input int s);
      foreach (q[i]) if (q[i] == s) return 1;
      return 0;
   endfunction

   task automatic step(input bit v, input int src, input int dst, input bit rq,
                       input bit hd, input int sz, input int addr, input int rdy,
                       input int ok, input int sat, input string tag);
      bit busy, gate, acc, enq, err, fv, fs;
      int fp, snp, others, tgt, strobe;
      @(negedge clk);
      snd_valid = v; snd_src = PW'(src); snd_dst = DW'(dst); snd_is_req = rq;
      snd_has_data = hd; snd_size = SW'(sz); snd_addr = AW'(addr);
      dst_ready = N'(rdy); snoop_ok = N'(ok); snoop_sat = N'(sat);
      #1;
      busy = (mbusy != 0);
      strobe = (!busy && q.size() > 0) ? (1 << q[0]) : 0;
      gate = busy || (q.size() > 0 && src != q[0]);
      others = (~(1 << src)) & 15;
      acc = 0; enq = 0; err = 0; fv = 0; fs = 0; fp = 0; snp = 0;
      if (v) begin
         if (gate) enq = 1;
         else if (dst != BCAST) begin
            if (dst >= N || dst == src) err = 1;
            else if (rdy[dst]) begin acc = 1; fv = 1; fp = dst; end
            else enq = 1;
         end else begin
            snp = others;
            tgt = addr / REGION;
            if ((others & ~ok & 15) != 0) enq = 1;
            else if ((others & sat) != 0) begin acc = 1; fs = 1; end
            else if (tgt == src) err = 1;
            else if (rdy[tgt]) begin acc = 1; fv = 1; fp = tgt; end
            else enq = 1;
         end
      end
      chk(hold_tag, "bus_busy", int'(bus_busy), int'(busy));
      chk("R6", "retry_strobe", int'(retry_strobe), strobe);
      chk(tag, "snd_accept", int'(snd_accept), int'(acc));
      chk("R11", "dest_err", int'(dest_err), int'(err));
      chk("R8", "snoop_req", int'(snoop_req), snp);
      chk("R9", "fwd_sat", int'(fwd_sat), int'(fs));
      chk("R10", "fwd_valid", int'(fwd_valid), int'(fv));
      if (fv) chk("R7", "fwd_port", int'(fwd_port), fp);
      if (acc) begin
         mbusy = exp_hold(rq, hd, sz);
         hold_tag = rq ? "R1" : (hd ? "R2" : "R3");
         if (q.size() > 0) void'(q.pop_front());
      end else begin
         if (enq && !in_q(src)) q.push_back(src);
         if (mbusy > 0) mbusy--;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 15, 0, "R6");
   endtask

   initial begin : watchdog
      #(4 * 150000);
      if (!done) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_0b05));
      repeat (4) @(negedge clk);
      #1;
      chk("R6", "reset retry_strobe", int'(retry_strobe), 0);
      chk("R4", "reset bus_busy", int'(bus_busy), 0);
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      // R1: request with data still holds one cycle
      step(1, 0, 1, 1, 1, 64, 0, 15, 15, 0, "R1"); idle(3);
      // R2: response data sizes 8, 9, 64
      step(1, 1, 2, 0, 1, 8, 0, 15, 15, 0, "R2"); idle(2);
      step(1, 1, 2, 0, 1, 9, 0, 15, 15, 0, "R2"); idle(3);
      step(1, 2, 0, 0, 1, 64, 0, 15, 15, 0, "R2"); idle(9);
      // R3: response without data
      step(1, 3, 0, 0, 0, 0, 0, 15, 15, 0, "R3"); idle(2);
      // R4/R5: busy refusal then strict order
      step(1, 0, 1, 0, 1, 24, 0, 15, 15, 0, "R2");
      step(1, 2, 1, 1, 0, 0, 0, 15, 15, 0, "R4");
      step(1, 3, 1, 1, 0, 0, 0, 15, 15, 0, "R4");
      step(1, 3, 1, 1, 0, 0, 0, 15, 15, 0, "R5");
      step(1, 3, 1, 1, 0, 0, 0, 15, 15, 0, "R5");
      step(1, 2, 1, 1, 0, 0, 0, 15, 15, 0, "R6");
      idle(1);
      step(1, 3, 1, 1, 0, 0, 0, 15, 15, 0, "R6"); idle(2);
      // R7: destination not ready, then ready
      step(1, 0, 2, 1, 0, 0, 0, 4'b1011, 15, 0, "R7");
      step(1, 0, 2, 1, 0, 0, 0, 15, 15, 0, "R7"); idle(2);
      // R8: snoop refusal
      step(1, 1, BCAST, 1, 0, 0, 0, 15, 4'b1011, 0, "R8");
      step(1, 1, BCAST, 1, 0, 0, 0, 15, 15, 4'b0100, "R9"); idle(2);
      // R10: decode 0x8000 -> port 2
      step(1, 0, BCAST, 1, 0, 0, 16'h8000, 15, 15, 0, "R10"); idle(2);
      step(1, 0, BCAST, 1, 0, 0, 16'hC100, 4'b0111, 15, 0, "R10");
      step(1, 0, BCAST, 1, 0, 0, 16'hC100, 15, 15, 0, "R10"); idle(2);
      // R11: illegal destinations are not queued
      step(1, 2, 2, 1, 0, 0, 0, 15, 15, 0, "R11");
      step(1, 2, 5, 1, 0, 0, 0, 15, 15, 0, "R11");
      step(1, 1, BCAST, 1, 0, 0, 16'h4000, 15, 15, 0, "R11");
      idle(2);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int dst, ok;
         dst = ($urandom_range(0, 1) == 1) ? BCAST : int'($urandom_range(0, 6));
         ok  = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 15)) : 15;
         if ($urandom_range(0, 3) == 0) idle(1);
         step(1, $urandom_range(0, 3), dst, $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(1, MB), $urandom_range(0, 65535), $urandom_range(0, 15),
              ok, ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 15)) : 0,
              (dst == BCAST) ? "R10" : "R5");
      end
      idle(12);
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule